// File: doc/BRIEF.md
# SPI Pin Override with Software Arbitration

This block sits between an on-chip SPI flash engine and the flash pins. Normally the engine's clock, select and data-out pass straight through to the pads. Host software can claim the pins by setting a request bit in the pin-access register. It then waits until a grant bit reads back as one, and from that point drives clock, select and data-out itself through register bits. It reads the flash's data-in through the same register. Clearing the request hands the pins back to the engine. This claim-and-release cycle can be repeated around every single flash command.

A second register holds a two-bit flash write-enable field. Only its two legal codes are accepted, and the field drives a write-permission output toward the flash path. The register port accepts one access per cycle and has no back-pressure. Every read is answered, with a response-valid pulse, on the cycle after it is accepted.

Top module: `spi_pin_override`

## Requirements
- R1: After reset, the pin-access register (byte offset 0x1C) reads 0x0000_0002, with select high and all else low. The control register (offset 0x10) reads 0x0000_0010, the field holding 01, and `flash_wr_en` is low. The pins follow the engine.
- R2: Pin-access bits are: bit 0 clock, bit 1 active-low select, bit 2 data-out. They are writable and read back as written.
- R3: Bit 4 is the request. Grant (bit 5, read-only) rises on the clock edge after request is seen high while `nat_busy` is low. It never rises while `nat_busy` is high.
- R4: Grant falls on the clock edge after request is seen low.
- R5: While grant is low, `spi_sck`, `spi_cs_n` and `spi_mosi` equal the engine's pins. While grant is high, they equal register bits 0, 1 and 2.
- R6: Control bits 5:4 are the write-enable field: 01 disables writes and 10 enables them. A write of 00 or 11 leaves the field unchanged. `flash_wr_en` is high exactly while the field holds 10.
- R7: Bit 3 shows `spi_miso` after a two-flop synchronizer. A change becomes readable to a read accepted on the third edge after it.
- R8: Writes to bits 3, 5, 30 and 31 of the pin-access register have no effect. Undefined bits of both registers read zero, and unmapped offsets read zero.
- R9: Bits 30 and 31 of the pin-access register read the engine's `nat_busy` and `nat_err` inputs.
- R10: Repeated request/grant/release cycles each complete with the same timing.
- R11: `reg_rvalid` is high for one cycle, on the cycle after each accepted read, with `reg_rdata` valid then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Access strobe, always accepted |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read response valid |
| nat_sck | input | 1 | Engine clock |
| nat_cs_n | input | 1 | Engine select |
| nat_mosi | input | 1 | Engine data-out |
| nat_busy | input | 1 | Engine transaction in progress |
| nat_err | input | 1 | Engine error |
| spi_sck | output | 1 | Flash clock pin |
| spi_cs_n | output | 1 | Flash select pin |
| spi_mosi | output | 1 | Flash data-out pin |
| spi_miso | input | 1 | Flash data-in pin |
| flash_wr_en | output | 1 | Flash write permission |

## Verification
A grant state that is wrong shows up directly at the pins. The pin outputs switch between engine and register values in the same cycle the grant changes, and the grant bit itself can be read two cycles after a request write. A corrupted write-enable field is visible at once on `flash_wr_en` and on the next control read. A synchronizer with the wrong depth shifts the first read that shows a new data-in value by a cycle, so the bench reads exactly at the edge where the value should first appear.

// File: rtl/spiov_pkg.sv
`timescale 1ns/1ps
package spiov_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned B_SCK     = 0;
  localparam int unsigned B_CS      = 1;
  localparam int unsigned B_MOSI    = 2;
  localparam int unsigned B_MISO    = 3;
  localparam int unsigned B_REQ     = 4;
  localparam int unsigned B_GNT     = 5;
  localparam int unsigned B_BUSY    = 30;
  localparam int unsigned B_ERR     = 31;
  localparam int unsigned B_WEN_LO  = 4;
  localparam logic [DW-1:0] PIN_WMASK = 32'h0000_0017;
  localparam logic [DW-1:0] PIN_RST   = 32'h0000_0002;

  typedef enum logic [1:0] {
    WEN_ILL0 = 2'b00,
    WEN_OFF  = 2'b01,
    WEN_ON   = 2'b10,
    WEN_ILL3 = 2'b11
  } wen_e;

  typedef struct packed {
    logic sck;
    logic cs_n;
    logic mosi;
  } spi_out_t;
endpackage

// File: rtl/spiov_sync.sv
`timescale 1ns/1ps
module spiov_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spiov_arbiter.sv
`timescale 1ns/1ps
module spiov_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic busy,
  output logic gnt
);
  logic gnt_d;

  always_comb begin
    if (!req)      gnt_d = 1'b0;
    else if (gnt)  gnt_d = 1'b1;
    else           gnt_d = !busy;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gnt <= 1'b0;
    else        gnt <= gnt_d;

  // R3: a grant only starts after request seen with the engine idle
  p_gnt_needs_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt) |-> $past(req && !busy));
  // R3: a busy engine keeps an ungranted bus ungranted
  p_busy_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt && busy) |=> !gnt);
  // R4: dropping request drops the grant on the next edge
  p_gnt_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !gnt);
endmodule

// File: rtl/spiov_regs.sv
`timescale 1ns/1ps
module spiov_regs
  import spiov_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] PIN_OFS  = 8'h1C,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_rvalid,
  input  logic              miso_s,
  input  logic              gnt,
  input  logic              busy,
  input  logic              err,
  output logic              req,
  output spi_out_t          sw_pins,
  output logic              flash_wr_en
);
  logic [DW-1:0] pin_q;
  wen_e          wen_q;
  logic          hit_pin, hit_ctrl, wr_ctrl;
  logic [1:0]    wen_in;
  logic [DW-1:0] rd_pin, rd_ctrl, rd_mux;

  assign hit_pin  = (reg_addr == PIN_OFS);
  assign hit_ctrl = (reg_addr == CTRL_OFS);
  assign wr_ctrl  = reg_en && reg_we && hit_ctrl;
  assign wen_in   = reg_wdata[B_WEN_LO+1:B_WEN_LO];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      pin_q <= PIN_RST;
    else if (reg_en && reg_we && hit_pin)
      pin_q <= (pin_q & ~PIN_WMASK) | (reg_wdata & PIN_WMASK);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      wen_q <= WEN_OFF;
    else if (wr_ctrl && (wen_in == WEN_OFF || wen_in == WEN_ON))
      wen_q <= wen_e'(wen_in);

  always_comb begin
    rd_pin          = pin_q & PIN_WMASK;
    rd_pin[B_MISO]  = miso_s;
    rd_pin[B_GNT]   = gnt;
    rd_pin[B_BUSY]  = busy;
    rd_pin[B_ERR]   = err;
    rd_ctrl         = '0;
    rd_ctrl[B_WEN_LO+1:B_WEN_LO] = wen_q;
    if (hit_pin)       rd_mux = rd_pin;
    else if (hit_ctrl) rd_mux = rd_ctrl;
    else               rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_en && !reg_we;
      if (reg_en && !reg_we) reg_rdata <= rd_mux;
    end

  assign req          = pin_q[B_REQ];
  assign sw_pins.sck  = pin_q[B_SCK];
  assign sw_pins.cs_n = pin_q[B_CS];
  assign sw_pins.mosi = pin_q[B_MOSI];
  assign flash_wr_en  = (wen_q == WEN_ON);

  // R6: the field never holds a forbidden code
  p_wen_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_q == WEN_OFF) || (wen_q == WEN_ON));
  // R6: forbidden codes leave the field as it was
  p_wen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && (wen_in == WEN_ILL0 || wen_in == WEN_ILL3)) |=> $stable(wen_q));
  // R11: a response only follows an accepted read
  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid |-> $past(reg_en && !reg_we));
endmodule

// File: rtl/spi_pin_override.sv
`timescale 1ns/1ps
module spi_pin_override
  import spiov_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  input  logic              nat_sck,
  input  logic              nat_cs_n,
  input  logic              nat_mosi,
  input  logic              nat_busy,
  input  logic              nat_err,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              flash_wr_en
);
  logic     miso_s, gnt, req;
  spi_out_t sw_pins;

  spiov_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(spi_miso), .q(miso_s));

  spiov_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .busy(nat_busy), .gnt(gnt));

  spiov_regs #(.ADDR_W(ADDR_W), .PIN_OFS(ADDR_W'(8'h1C)), .CTRL_OFS(ADDR_W'(8'h10))) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .miso_s(miso_s), .gnt(gnt), .busy(nat_busy),
    .err(nat_err), .req(req), .sw_pins(sw_pins), .flash_wr_en(flash_wr_en));

  always_comb begin
    if (gnt) begin
      spi_sck  = sw_pins.sck;
      spi_cs_n = sw_pins.cs_n;
      spi_mosi = sw_pins.mosi;
    end else begin
      spi_sck  = nat_sck;
      spi_cs_n = nat_cs_n;
      spi_mosi = nat_mosi;
    end
  end

  // R5: pins leave the engine only while a request is standing
  p_pins_need_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck != nat_sck) |-> $past(req));
endmodule

// File: tb/spi_pin_override_tb.sv
`timescale 1ns/1ps
module spi_pin_override_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_en = 0, reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic reg_rvalid;
  logic nat_sck = 0, nat_cs_n = 1, nat_mosi = 0, nat_busy = 0, nat_err = 0;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso = 0, flash_wr_en;

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  spi_pin_override dut_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .nat_sck(nat_sck), .nat_cs_n(nat_cs_n),
    .nat_mosi(nat_mosi), .nat_busy(nat_busy), .nat_err(nat_err),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .flash_wr_en(flash_wr_en));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when a response appears
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) check(1, 0, "R11 unexpected response");
      else check(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    reg_en = 1; reg_we = 0; reg_addr = a;
    @(negedge clk);
    reg_en = 0;
  endtask

  task automatic pins(input logic s, input logic c, input logic m, input string tag);
    check({29'b0, spi_sck, spi_cs_n, spi_mosi}, {29'b0, s, c, m}, tag);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    rd(8'h1C, 32'h0000_0002, "R1 pin reg reset");
    rd(8'h10, 32'h0000_0010, "R1 ctrl reset");
    check({31'b0, flash_wr_en}, 0, "R1 wr_en reset");
    nat_sck = 1; nat_cs_n = 0; nat_mosi = 1;
    #1 pins(1, 0, 1, "R1 pins follow engine");
    idle(1);

    // R2/R8: write pin bits without request, ignored bits set
    wr(8'h1C, 32'hC000_002D);
    rd(8'h1C, 32'h0000_0005, "R2 R8 write readback");
    pins(1, 0, 1, "R5 no grant keeps engine");
    rd(8'h44, 32'h0, "R8 unmapped reads zero");
    rd(8'h1C, 32'h0000_0005, "R8 still no grant");

    // R9 status inputs
    nat_busy = 1; nat_err = 1;
    rd(8'h1C, 32'hC000_0005, "R9 busy err visible");
    nat_err = 0;

    // R3: request while busy never grants
    wr(8'h1C, 32'h0000_0012);
    idle(3);
    rd(8'h1C, 32'h4000_0012, "R3 busy blocks grant");
    pins(1, 0, 1, "R5 busy engine keeps pins");
    nat_busy = 0;
    idle(1);
    rd(8'h1C, 32'h0000_0032, "R3 grant after idle");
    pins(0, 1, 0, "R5 pins follow register");
    wr(8'h1C, 32'h0000_0015);
    pins(1, 0, 1, "R5 register drives pins");
    nat_sck = 0; nat_cs_n = 1; nat_mosi = 0;
    #1 pins(1, 0, 1, "R5 engine ignored while granted");
    idle(1);

    // R7 MISO synchronizer timing
    spi_miso = 1;
    idle(1);
    rd(8'h1C, 32'h0000_0035, "R7 second edge not yet");
    rd(8'h1C, 32'h0000_003D, "R7 third edge visible");
    spi_miso = 0;
    idle(2);

    // R4 release
    wr(8'h1C, 32'h0000_0002);
    idle(1);
    pins(0, 1, 0, "R4 pins back to engine");
    rd(8'h1C, 32'h0000_0002, "R4 grant dropped");

    // R10 repeated cycles
    for (int k = 0; k < 5; k++) begin
      wr(8'h1C, 32'h0000_0010);
      idle(1);
      rd(8'h1C, 32'h0000_0030, "R10 grant cycle");
      wr(8'h1C, 32'h0000_0002);
      idle(1);
      rd(8'h1C, 32'h0000_0002, "R10 release cycle");
    end

    // R6 write-enable field
    wr(8'h10, 32'h0000_0020);
    rd(8'h10, 32'h0000_0020, "R6 enable code");
    check({31'b0, flash_wr_en}, 1, "R6 wr_en high");
    wr(8'h10, 32'h0000_0030);
    rd(8'h10, 32'h0000_0020, "R6 code 11 ignored");
    wr(8'h10, 32'h0000_0000);
    rd(8'h10, 32'h0000_0020, "R6 code 00 ignored");
    check({31'b0, flash_wr_en}, 1, "R6 wr_en held");
    wr(8'h10, 32'hFFFF_FF1F);
    rd(8'h10, 32'h0000_0010, "R6 R8 disable code");
    check({31'b0, flash_wr_en}, 0, "R6 wr_en low");

    idle(3);
    check(exp_q.size(), 0, "R11 all reads answered");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule